// File: doc/BRIEF.md
# Virtual-8086 Software Interrupt Dispatcher

This block decides what happens when a task running in virtual-8086 mode executes a software interrupt instruction with vector n. It takes the virtual-mode extension enable, the current 16-bit FLAGS word (which carries the I/O privilege level), the virtual interrupt flag, the interrupt-redirection bit for vector n, and the current CS, IP and SP. It chooses one of three outcomes:

- hand the interrupt to the protected-mode handler;
- raise a general-protection fault;
- redirect it inside the task to an 8086-style handler.

For a redirect, the block prepares everything the memory sequencer needs:

- the FLAGS image to push, rewritten according to the privilege case;
- the CS and IP words to push, each with the stack offset it goes to;
- the stack pointer after the pushes;
- the live FLAGS and virtual interrupt flag after entry;
- the two addresses in the real-mode vector table that hold the handler's far pointer.

The block performs no memory accesses and does not walk the protected-mode gate path. A request is a single-cycle `req_valid` pulse. Every result is registered and appears together with `act_valid` on the following clock cycle. The results hold until the next request.

Top module: `v86_int_dispatch`

## Requirements
- R1: The action appears one cycle after `req_valid` as a one-hot 3-bit code: bit 0 selects the protected-mode handler, bit 1 a general-protection fault, and bit 2 the redirect. `act_valid` is high in that cycle only. When `act_valid` is high exactly one action bit is set.
- R2: The privilege level is `flags_in[13:12]`. With `vme`=0, a level of 3 selects the protected-mode handler and any lower level selects the fault, whatever `redir_bit` is.
- R3: With `vme`=1 and `redir_bit`=1, a level of 3 selects the protected-mode handler and any lower level selects the fault.
- R4: With `vme`=1, `redir_bit`=0 and a level of 3, the action is redirect. The pushed FLAGS image is `flags_in` with NT (bit 14) and the privilege field (bits 13:12) cleared.
- R5: In the redirect case of R4, the live FLAGS output is `flags_in` with IF (bit 9) and TF (bit 8) cleared. `new_vif` equals `vif_in`.
- R6: With `vme`=1, `redir_bit`=0 and a level below 3, the action is redirect. The pushed FLAGS image is `flags_in` with bits 13:12 set to 3 and bit 9 replaced by `vif_in`.
- R7: In the redirect case of R6, the live FLAGS output is `flags_in` with TF cleared and IF untouched, and `new_vif` is 0.
- R8: On a redirect, the stack is written at three offsets:
  - FLAGS at SP-2;
  - CS at SP-4;
  - IP at SP-6.

  `push_cs` and `push_ip` equal `cs_in` and `ip_in`. `new_sp` is SP-6. All stack arithmetic is modulo 2^16.
- R9: The vector-table offset word for vector n is at linear address n*4. The segment word is at n*4+2. Both are zero-extended to `ADDR_W` bits.
- R10: When the action is not redirect, `new_flags`, `new_vif` and `new_sp` equal `flags_in`, `vif_in` and `sp_in`.
- R11: During and straight after reset, `act_valid` is 0 and `act` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| vme | input | 1 | Virtual-mode extensions enabled |
| redir_bit | input | 1 | Redirection-map bit for this vector |
| vector | input | VEC_W | Interrupt vector n |
| flags_in | input | WORD_W | Current FLAGS, privilege level in bits 13:12 |
| vif_in | input | 1 | Current virtual interrupt flag |
| cs_in | input | WORD_W | Current code segment |
| ip_in | input | WORD_W | Return offset |
| sp_in | input | WORD_W | Current stack pointer |
| act_valid | output | 1 | Result strobe |
| act | output | 3 | One-hot action |
| push_flags | output | WORD_W | FLAGS image to push (0 when not redirecting) |
| push_cs | output | WORD_W | CS word to push |
| push_ip | output | WORD_W | IP word to push |
| addr_flags | output | WORD_W | Stack offset for the FLAGS word |
| addr_cs | output | WORD_W | Stack offset for the CS word |
| addr_ip | output | WORD_W | Stack offset for the IP word |
| new_sp | output | WORD_W | Stack pointer after the action |
| new_flags | output | WORD_W | Live FLAGS after the action |
| new_vif | output | 1 | Live virtual interrupt flag after the action |
| ivt_off_addr | output | ADDR_W | Vector-table address of the handler offset |
| ivt_seg_addr | output | ADDR_W | Vector-table address of the handler segment |

## Verification
The assertions check on every cycle that a request always yields exactly one action on the next edge, and that a request with extensions off never redirects. They also check that a redirect always clears TF and moves SP by six, and that a non-redirect leaves FLAGS untouched. Only the bench scenarios can show that each cell of the three-input truth table maps to the correct action, and that the two redirect cases rewrite the pushed image differently. The bench also covers the placement of VIF into the IF position, stack wraparound below zero, and the vector-table addresses at the lowest and highest vectors.

// File: rtl/v86_disp_pkg.sv
package v86_disp_pkg;
   // Architectural FLAGS bit positions
   localparam int FL_TF      = 8;
   localparam int FL_IF      = 9;
   localparam int FL_IOPL_LO = 12;
   localparam int FL_NT      = 14;

   // One-hot action bit indices
   localparam int ACT_PM = 0;
   localparam int ACT_GP = 1;
   localparam int ACT_RD = 2;
   localparam int ACT_W  = 3;

   typedef enum logic [1:0] {
      RD_NONE = 2'd0,  // no redirect
      RD_FULL = 2'd1,  // privilege level 3
      RD_VIRT = 2'd2   // privilege level below 3, virtual flags in use
   } redir_kind_e;
endpackage

// File: rtl/v86_decide.sv
module v86_decide
   import v86_disp_pkg::*;
(
   input  logic             vme,
   input  logic [1:0]       iopl,
   input  logic             redir_bit,
   output logic [ACT_W-1:0] act,
   output redir_kind_e      kind
);
   logic lvl3;
   assign lvl3 = &iopl;

   always_comb begin
      act  = '0;
      kind = RD_NONE;
      if (!vme || redir_bit) begin
         act[lvl3 ? ACT_PM : ACT_GP] = 1'b1;
      end else begin
         act[ACT_RD] = 1'b1;
         kind        = lvl3 ? RD_FULL : RD_VIRT;
      end
   end
endmodule

// File: rtl/v86_frame.sv
module v86_frame
   import v86_disp_pkg::*;
#(
   parameter int WORD_W = 16
)(
   input  redir_kind_e        kind,
   input  logic [WORD_W-1:0]  flags_in,
   input  logic               vif_in,
   input  logic [WORD_W-1:0]  cs_in,
   input  logic [WORD_W-1:0]  ip_in,
   input  logic [WORD_W-1:0]  sp_in,
   output logic [WORD_W-1:0]  push_flags,
   output logic [WORD_W-1:0]  push_cs,
   output logic [WORD_W-1:0]  push_ip,
   output logic [WORD_W-1:0]  addr_flags,
   output logic [WORD_W-1:0]  addr_cs,
   output logic [WORD_W-1:0]  addr_ip,
   output logic [WORD_W-1:0]  new_sp,
   output logic [WORD_W-1:0]  new_flags,
   output logic               new_vif
);
   localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

   logic [WORD_W-1:0] img;

   assign addr_flags = sp_in - STEP;
   assign addr_cs    = addr_flags - STEP;
   assign addr_ip    = addr_cs - STEP;
   assign push_cs    = cs_in;
   assign push_ip    = ip_in;

   always_comb begin
      img       = flags_in;
      new_flags = flags_in;
      new_vif   = vif_in;
      new_sp    = sp_in;
      case (kind)
         RD_FULL: begin
            img[FL_NT]           = 1'b0;
            img[FL_IOPL_LO +: 2] = 2'b00;
            new_flags[FL_IF]     = 1'b0;
            new_flags[FL_TF]     = 1'b0;
            new_sp               = addr_ip;
         end
         RD_VIRT: begin
            img[FL_IOPL_LO +: 2] = 2'b11;
            img[FL_IF]           = vif_in;
            new_flags[FL_TF]     = 1'b0;
            new_vif              = 1'b0;
            new_sp               = addr_ip;
         end
         default: ;
      endcase
      push_flags = (kind == RD_NONE) ? '0 : img;
   end
endmodule

// File: rtl/v86_ivt_addr.sv
module v86_ivt_addr #(
   parameter int VEC_W  = 8,
   parameter int ADDR_W = 20
)(
   input  logic [VEC_W-1:0]  vector,
   output logic [ADDR_W-1:0] off_addr,
   output logic [ADDR_W-1:0] seg_addr
);
   localparam int ENT_W = VEC_W + 2;

   logic [ENT_W-1:0] ent;
   assign ent = {vector, 2'b00};

   generate
      if (ADDR_W == ENT_W) begin : g_exact
         assign off_addr = ent;
         assign seg_addr = ent | ENT_W'(2);
      end else begin : g_wide
         assign off_addr = {{(ADDR_W-ENT_W){1'b0}}, ent};
         assign seg_addr = {{(ADDR_W-ENT_W){1'b0}}, ent | ENT_W'(2)};
      end
   endgenerate
endmodule

// File: rtl/v86_int_dispatch.sv
module v86_int_dispatch
   import v86_disp_pkg::*;
#(
   parameter int VEC_W  = 8,
   parameter int WORD_W = 16,
   parameter int ADDR_W = 20
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              vme,
   input  logic              redir_bit,
   input  logic [VEC_W-1:0]  vector,
   input  logic [WORD_W-1:0] flags_in,
   input  logic              vif_in,
   input  logic [WORD_W-1:0] cs_in,
   input  logic [WORD_W-1:0] ip_in,
   input  logic [WORD_W-1:0] sp_in,
   output logic              act_valid,
   output logic [2:0]        act,
   output logic [WORD_W-1:0] push_flags,
   output logic [WORD_W-1:0] push_cs,
   output logic [WORD_W-1:0] push_ip,
   output logic [WORD_W-1:0] addr_flags,
   output logic [WORD_W-1:0] addr_cs,
   output logic [WORD_W-1:0] addr_ip,
   output logic [WORD_W-1:0] new_sp,
   output logic [WORD_W-1:0] new_flags,
   output logic              new_vif,
   output logic [ADDR_W-1:0] ivt_off_addr,
   output logic [ADDR_W-1:0] ivt_seg_addr
);
   localparam logic [WORD_W-1:0] FRAME_SZ = WORD_W'(3 * (WORD_W / 8));

   generate
      if (WORD_W != 16) begin : g_bad_word
         $error("v86_int_dispatch: WORD_W must be 16");
      end
      if (ADDR_W < VEC_W + 2) begin : g_bad_addr
         $error("v86_int_dispatch: ADDR_W too narrow for vector table");
      end
   endgenerate

   logic [ACT_W-1:0]  act_c;
   redir_kind_e       kind_c;
   logic [WORD_W-1:0] pf_c, pc_c, pi_c, af_c, ac_c, ai_c, sp_c, nf_c;
   logic              nv_c;
   logic [ADDR_W-1:0] io_c, is_c;

   v86_decide u_decide (
      .vme       (vme),
      .iopl      (flags_in[FL_IOPL_LO +: 2]),
      .redir_bit (redir_bit),
      .act       (act_c),
      .kind      (kind_c)
   );

   v86_frame #(.WORD_W(WORD_W)) u_frame (
      .kind       (kind_c),
      .flags_in   (flags_in),
      .vif_in     (vif_in),
      .cs_in      (cs_in),
      .ip_in      (ip_in),
      .sp_in      (sp_in),
      .push_flags (pf_c),
      .push_cs    (pc_c),
      .push_ip    (pi_c),
      .addr_flags (af_c),
      .addr_cs    (ac_c),
      .addr_ip    (ai_c),
      .new_sp     (sp_c),
      .new_flags  (nf_c),
      .new_vif    (nv_c)
   );

   v86_ivt_addr #(.VEC_W(VEC_W), .ADDR_W(ADDR_W)) u_ivt (
      .vector   (vector),
      .off_addr (io_c),
      .seg_addr (is_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_valid <= 1'b0;
         act       <= '0;
      end else begin
         act_valid <= req_valid;
         if (req_valid) act <= act_c;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         push_flags   <= '0;
         push_cs      <= '0;
         push_ip      <= '0;
         addr_flags   <= '0;
         addr_cs      <= '0;
         addr_ip      <= '0;
         new_sp       <= '0;
         new_flags    <= '0;
         new_vif      <= 1'b0;
         ivt_off_addr <= '0;
         ivt_seg_addr <= '0;
      end else if (req_valid) begin
         push_flags   <= pf_c;
         push_cs      <= pc_c;
         push_ip      <= pi_c;
         addr_flags   <= af_c;
         addr_cs      <= ac_c;
         addr_ip      <= ai_c;
         new_sp       <= sp_c;
         new_flags    <= nf_c;
         new_vif      <= nv_c;
         ivt_off_addr <= io_c;
         ivt_seg_addr <= is_c;
      end
   end

   // R1: one action bit per result
   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> $countones(act) == 1);

   // R1: result follows request by one cycle
   p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> act_valid);

   // R2: extensions off never redirect
   p_novme_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !vme) |=> !act[ACT_RD]);

   // R5/R7: trap flag always cleared on redirect
   p_tf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && act[ACT_RD]) |-> !new_flags[FL_TF]);

   // R8: redirect consumes a three-word frame
   p_frame_sp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (!act[ACT_RD] || new_sp == $past(sp_in) - FRAME_SZ));

   // R10: no redirect leaves flags untouched
   p_keep_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (act[ACT_RD] || new_flags == $past(flags_in)));
endmodule

// File: tb/sim_v86_int_dispatch.sv
`timescale 1ns/1ps
module sim_v86_int_dispatch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, vme = 1'b0, redir_bit = 1'b0, vif_in = 1'b0;
   logic [7:0]  vector = '0;
   logic [15:0] flags_in = '0, cs_in = '0, ip_in = '0, sp_in = '0;
   logic        act_valid, new_vif;
   logic [2:0]  act;
   logic [15:0] push_flags, push_cs, push_ip, addr_flags, addr_cs, addr_ip, new_sp, new_flags;
   logic [19:0] ivt_off_addr, ivt_seg_addr;

   int checks = 0, fails = 0;
   bit done = 0;

   always #4 clk = ~clk;  // 125 MHz

   v86_int_dispatch u0 (.*);

   typedef struct packed {
      logic        v;
      logic        rb;
      logic        vf;
      logic [15:0] fl;
      logic [7:0]  n;
      logic [2:0]  ea;
   } vec_t;

   // act: bit0 protected-mode, bit1 fault, bit2 redirect
   localparam vec_t TBL [11] = '{
      '{1'b0, 1'b0, 1'b0, 16'h3202, 8'h10, 3'b001},  // R2
      '{1'b0, 1'b1, 1'b1, 16'h3202, 8'h21, 3'b001},  // R2
      '{1'b0, 1'b0, 1'b1, 16'h1202, 8'h13, 3'b010},  // R2
      '{1'b0, 1'b1, 1'b0, 16'h0002, 8'h08, 3'b010},  // R2
      '{1'b1, 1'b1, 1'b0, 16'h3302, 8'h1A, 3'b001},  // R3
      '{1'b1, 1'b1, 1'b1, 16'h2302, 8'h2F, 3'b010},  // R3
      '{1'b1, 1'b0, 1'b0, 16'h7302, 8'h21, 3'b100},  // R4/R5
      '{1'b1, 1'b0, 1'b1, 16'hF3D5, 8'h80, 3'b100},  // R4/R5
      '{1'b1, 1'b0, 1'b1, 16'h0202, 8'h16, 3'b100},  // R6/R7
      '{1'b1, 1'b0, 1'b0, 16'h2302, 8'h33, 3'b100},  // R6/R7
      '{1'b1, 1'b0, 1'b1, 16'h1000, 8'h05, 3'b100}   // R6/R7
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [15:0] exp_push(input logic [15:0] f, input logic vf);
      logic [15:0] r = f;
      if (f[13:12] == 2'b11) begin r[14] = 1'b0; r[13:12] = 2'b00; end
      else begin r[13:12] = 2'b11; r[9] = vf; end
      return r;
   endfunction

   function automatic logic [15:0] exp_live(input logic [15:0] f);
      logic [15:0] r = f;
      r[8] = 1'b0;
      if (f[13:12] == 2'b11) r[9] = 1'b0;
      return r;
   endfunction

   task automatic apply(input vec_t t, input logic [15:0] sp);
      @(negedge clk);
      vme = t.v; redir_bit = t.rb; vif_in = t.vf; flags_in = t.fl; vector = t.n;
      cs_in = 16'hB800 ^ {8'h00, t.n}; ip_in = 16'h0123 + {8'h00, t.n}; sp_in = sp;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1 valid", {31'd0, act_valid}, 32'd1);
      chk("R1/R2/R3 act", {29'd0, act}, {29'd0, t.ea});
      chk("R9 ivt off", {12'd0, ivt_off_addr}, {22'd0, t.n, 2'b00});
      chk("R9 ivt seg", {12'd0, ivt_seg_addr}, {22'd0, t.n, 2'b10});
      if (t.ea[2]) begin
         chk(t.fl[13:12] == 2'b11 ? "R4 push flags" : "R6 push flags",
             {16'd0, push_flags}, {16'd0, exp_push(t.fl, t.vf)});
         chk(t.fl[13:12] == 2'b11 ? "R5 live flags" : "R7 live flags",
             {16'd0, new_flags}, {16'd0, exp_live(t.fl)});
         chk(t.fl[13:12] == 2'b11 ? "R5 vif" : "R7 vif",
             {31'd0, new_vif}, {31'd0, (t.fl[13:12] == 2'b11) ? t.vf : 1'b0});
         chk("R8 cs", {16'd0, push_cs}, {16'd0, cs_in});
         chk("R8 ip", {16'd0, push_ip}, {16'd0, ip_in});
         chk("R8 addr flags", {16'd0, addr_flags}, {16'd0, sp - 16'd2});
         chk("R8 addr cs", {16'd0, addr_cs}, {16'd0, sp - 16'd4});
         chk("R8 addr ip", {16'd0, addr_ip}, {16'd0, sp - 16'd6});
         chk("R8 new sp", {16'd0, new_sp}, {16'd0, sp - 16'd6});
      end else begin
         chk("R10 flags", {16'd0, new_flags}, {16'd0, t.fl});
         chk("R10 vif", {31'd0, new_vif}, {31'd0, t.vf});
         chk("R10 sp", {16'd0, new_sp}, {16'd0, sp});
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 reset valid", {31'd0, act_valid}, 32'd0);
      chk("R11 reset act", {29'd0, act}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 after reset", {28'd0, act_valid, act}, 32'd0);

      for (int i = 0; i < 11; i++) apply(TBL[i], 16'h0FF0 + 16'(i * 16));

      // R8: stack wraps below zero
      apply('{1'b1, 1'b0, 1'b0, 16'h3302, 8'h00, 3'b100}, 16'h0004);
      // R9: highest vector
      apply('{1'b1, 1'b0, 1'b1, 16'h0200, 8'hFF, 3'b100}, 16'h8000);
      // R1: no request, strobe drops
      @(negedge clk);
      chk("R1 strobe drops", {31'd0, act_valid}, 32'd0);
      // R2: fault with level 2 and redirect bit 0
      apply('{1'b0, 1'b0, 1'b1, 16'h2000, 8'h21, 3'b010}, 16'h1000);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule